// File: doc/BRIEF.md
# T1 Line Alarm Detector

This block watches a received T1 bit stream, one bit per cycle in which the bit-clock enable is high, and reports the line alarms: carrier loss, runs of eight and sixteen zeros, the all-ones (blue) alarm and the far-end (yellow) alarm. The yellow alarm is recognised in one of three formats, selected by the frame mode. An external framer supplies the position markers: the F-bit marker, the frame number, the bit position within the channel and the data-link marker.

Each live alarm level is also captured in a sticky status register. A single-cycle read pulse clears that register, except on a burst read and except for bits whose condition is still present. A second register records the ends of carrier loss and of the blue alarm. An active-low interrupt combines both registers through per-bit masks.

Top module: `t1_alarm_detect`

## Requirements
- R1: `zero8` is high while the current run of consecutive zero bits has a length of 8 or more. `zero16` is high while the run has a length of 16 or more. Both drop on the next one bit.
- R2: `carrierLoss` rises when the 192nd consecutive zero bit is received, and not before.
- R3: While carrier loss is declared, the bits are grouped into blocks of 112, starting with the bit after the declaration. Carrier loss ends at the end of the first block that holds 14 or more ones.
- R4: The stream is cut into windows of 4632 bits, counted from reset. At the end of each window `blueAlarm` becomes 1 if the window held 5 or fewer zeros, and 0 if it held 6 or more.
- R5: With `esfMode`=0 and `sbitYelMode`=0, a bit with `bitPos`=1 and `fBitMark`=0 is bit 2 of a channel. Yellow is declared after 256 consecutive such bits equal to zero. It clears on the first such bit equal to one. Bits at other positions are ignored.
- R6: With `esfMode`=0 and `sbitYelMode`=1, yellow takes the value of the F-bit of frame 12 (`fBitMark`=1, `frameNum`=12). F-bits of other frames are ignored.
- R7: With `esfMode`=1, data-link bits (`fBitMark`=1, `fdlMark`=1) form 16-bit codewords: eight zeros, then eight ones. Yellow is declared once 16 such codewords have been received back to back. It clears at the end of the first codeword that differs.
- R8: `statusAlarm` bit 0 = carrier loss, bit 1 = 8-zero, bit 2 = 16-zero, bit 3 = blue, bit 4 = yellow. Each bit is set one cycle after its live level is high and stays set. A read with `rdSel`=0 and `rdBurst`=0 clears every bit whose live level is low. A burst read changes nothing.
- R9: `statusClear` bit 0 sets when carrier loss ends, and bit 1 sets when the blue alarm ends. A non-burst read with `rdSel`=1 clears both bits.
- R10: `irqN` is low exactly when some status bit is set and its bit in `maskAlarm` or `maskClear` is 1.
- R11: A cycle with `bitEn`=0 advances no counter and changes no live alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low synchronous reset |
| bitEn | input | 1 | a received bit is present this cycle |
| rxData | input | 1 | received bit value |
| fBitMark | input | 1 | current bit is an F-bit |
| frameNum | input | 5 | frame number within the multiframe, 1-based |
| bitPos | input | 3 | bit index within the channel, 0 = first |
| fdlMark | input | 1 | current F-bit carries data-link data |
| esfMode | input | 1 | extended superframe mode (data-link yellow) |
| sbitYelMode | input | 1 | superframe yellow from the frame-12 F-bit |
| rdEn | input | 1 | one-cycle status read pulse |
| rdSel | input | 1 | 0 = alarm status, 1 = clear-event status |
| rdBurst | input | 1 | read is a burst read (no clearing) |
| maskAlarm | input | 5 | interrupt enables for `statusAlarm` |
| maskClear | input | 2 | interrupt enables for `statusClear` |
| carrierLoss | output | 1 | live carrier-loss level |
| zero8 | output | 1 | live 8-zero run level |
| zero16 | output | 1 | live 16-zero run level |
| blueAlarm | output | 1 | live all-ones alarm level |
| yellowAlarm | output | 1 | live yellow alarm level |
| statusAlarm | output | 5 | sticky alarm status |
| statusClear | output | 2 | sticky alarm-ended status |
| irqN | output | 1 | active-low interrupt |

## Verification
Every live alarm is registered, so it changes at the clock edge that samples the deciding bit and is visible in the following cycle. The status registers take one more edge, and `irqN` follows the status registers with no further delay. After the deciding bit, the bench holds `bitEn` low and checks the live levels at the next falling edge and the status bits one falling edge later. These idle cycles also exercise R11, because the block must hold its counters while they run. Read effects are checked at the falling edge right after the read pulse.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;

  typedef enum logic [1:0] {
    YEL_BIT2 = 2'd0,
    YEL_SBIT = 2'd1,
    YEL_FDL  = 2'd2
  } yel_mode_e;

  // strobes from control to datapath, all qualified by the bit enable
  typedef struct packed {
    logic take;
    logic isOne;
    logic bit2Slot;
    logic sFrame12;
    logic fdlSlot;
  } strobe_t;

  // levels and one-cycle events from datapath to control
  typedef struct packed {
    logic carrier;
    logic zero8;
    logic zero16;
    logic blue;
    logic yellow;
    logic carrierEnd;
    logic blueEnd;
  } live_t;

endpackage

// File: rtl/t1_alarm_path.sv
module t1_alarm_path
  import t1_alarm_pkg::*;
#(
  parameter int CL_RUN    = 192,
  parameter int CL_BLK    = 112,
  parameter int CL_ONES   = 14,
  parameter int AIS_WIN   = 4632,
  parameter int AIS_MAXZ  = 5,
  parameter int Y2_RUN    = 256,
  parameter int FDL_REPS  = 16,
  parameter int RUN_SHORT = 8,
  parameter int RUN_LONG  = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output live_t   live
);

  localparam int ZW = $clog2(CL_RUN + 1);
  localparam int BW = $clog2(CL_BLK);
  localparam int OW = $clog2(CL_ONES + 1);
  localparam int AW = $clog2(AIS_WIN);
  localparam int NW = $clog2(AIS_MAXZ + 2);
  localparam int YW = $clog2(Y2_RUN + 1);
  localparam int RW = $clog2(FDL_REPS + 1);
  localparam logic [15:0] FDL_WORD = 16'h00FF;

  logic [ZW-1:0] zeroRun;
  logic          clAct, clEndP;
  logic [BW-1:0] blkCnt;
  logic [OW-1:0] onesCnt, onesNext;
  logic [AW-1:0] aisCnt;
  logic [NW-1:0] aisZ, aisZNext;
  logic          blueAct, blueEndP;
  logic [YW-1:0] y2Cnt;
  logic          yellow;
  logic [15:0]   fdlSr, fdlNext;
  logic [3:0]    fdlPh;
  logic [RW-1:0] fdlReps;

  always_comb begin
    onesNext = (stb.isOne && onesCnt != OW'(CL_ONES)) ? onesCnt + 1'b1 : onesCnt;
    aisZNext = (!stb.isOne && aisZ != NW'(AIS_MAXZ + 1)) ? aisZ + 1'b1 : aisZ;
    fdlNext  = {fdlSr[14:0], stb.isOne};
  end

  // zero run length, saturating
  always_ff @(posedge clk) begin
    if (!rstN) zeroRun <= '0;
    else if (stb.take) begin
      if (stb.isOne) zeroRun <= '0;
      else if (zeroRun != ZW'(CL_RUN)) zeroRun <= zeroRun + 1'b1;
    end
  end

  // carrier loss: declare on long run, release on block ones density
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clAct <= 1'b0; blkCnt <= '0; onesCnt <= '0; clEndP <= 1'b0;
    end else begin
      clEndP <= 1'b0;
      if (stb.take) begin
        if (!clAct) begin
          blkCnt  <= '0;
          onesCnt <= '0;
          if (!stb.isOne && zeroRun == ZW'(CL_RUN - 1)) clAct <= 1'b1;
        end else if (blkCnt == BW'(CL_BLK - 1)) begin
          blkCnt  <= '0;
          onesCnt <= '0;
          if (onesNext == OW'(CL_ONES)) begin
            clAct  <= 1'b0;
            clEndP <= 1'b1;
          end
        end else begin
          blkCnt  <= blkCnt + 1'b1;
          onesCnt <= onesNext;
        end
      end
    end
  end

  // blue alarm: zeros per fixed window, decided at window end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aisCnt <= '0; aisZ <= '0; blueAct <= 1'b0; blueEndP <= 1'b0;
    end else begin
      blueEndP <= 1'b0;
      if (stb.take) begin
        if (aisCnt == AW'(AIS_WIN - 1)) begin
          aisCnt <= '0;
          aisZ   <= '0;
          if (aisZNext <= NW'(AIS_MAXZ)) blueAct <= 1'b1;
          else begin
            blueAct  <= 1'b0;
            blueEndP <= blueAct;
          end
        end else begin
          aisCnt <= aisCnt + 1'b1;
          aisZ   <= aisZNext;
        end
      end
    end
  end

  // yellow alarm, one of three formats via mutually exclusive strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      y2Cnt <= '0; yellow <= 1'b0; fdlSr <= '0; fdlPh <= '0; fdlReps <= '0;
    end else begin
      if (stb.bit2Slot) begin
        if (stb.isOne) begin
          y2Cnt  <= '0;
          yellow <= 1'b0;
        end else if (y2Cnt != YW'(Y2_RUN)) begin
          y2Cnt <= y2Cnt + 1'b1;
          if (y2Cnt == YW'(Y2_RUN - 1)) yellow <= 1'b1;
        end
      end
      if (stb.sFrame12) yellow <= stb.isOne;
      if (stb.fdlSlot) begin
        fdlSr <= fdlNext;
        if (fdlReps == '0) begin
          if (fdlNext == FDL_WORD) begin
            fdlReps <= RW'(1);
            fdlPh   <= '0;
          end
        end else begin
          fdlPh <= fdlPh + 1'b1;
          if (fdlPh == 4'd15) begin
            if (fdlNext == FDL_WORD) begin
              if (fdlReps != RW'(FDL_REPS)) fdlReps <= fdlReps + 1'b1;
              if (fdlReps == RW'(FDL_REPS - 1)) yellow <= 1'b1;
            end else begin
              fdlReps <= '0;
              yellow  <= 1'b0;
            end
          end
        end
      end
    end
  end

  always_comb begin
    live.carrier    = clAct;
    live.zero8      = zeroRun >= ZW'(RUN_SHORT);
    live.zero16     = zeroRun >= ZW'(RUN_LONG);
    live.blue       = blueAct;
    live.yellow     = yellow;
    live.carrierEnd = clEndP;
    live.blueEnd    = blueEndP;
  end

endmodule

// File: rtl/t1_alarm_ctrl.sv
module t1_alarm_ctrl
  import t1_alarm_pkg::*;
#(
  parameter int FRAME_SBIT = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxData,
  input  logic       fBitMark,
  input  logic [4:0] frameNum,
  input  logic [2:0] bitPos,
  input  logic       fdlMark,
  input  logic       esfMode,
  input  logic       sbitYelMode,
  input  logic       rdEn,
  input  logic       rdSel,
  input  logic       rdBurst,
  input  logic [4:0] maskAlarm,
  input  logic [1:0] maskClear,
  input  live_t      live,
  output strobe_t    stb,
  output logic [4:0] statusAlarm,
  output logic [1:0] statusClear,
  output logic       irqN
);

  yel_mode_e yelMode;
  logic      clrAlarm, clrEvent;
  logic [4:0] alarmNow;

  always_comb begin
    if (esfMode)          yelMode = YEL_FDL;
    else if (sbitYelMode) yelMode = YEL_SBIT;
    else                  yelMode = YEL_BIT2;

    stb.take     = bitEn;
    stb.isOne    = rxData;
    stb.bit2Slot = bitEn && !fBitMark && bitPos == 3'd1 && yelMode == YEL_BIT2;
    stb.sFrame12 = bitEn && fBitMark && frameNum == 5'(FRAME_SBIT) && yelMode == YEL_SBIT;
    stb.fdlSlot  = bitEn && fBitMark && fdlMark && yelMode == YEL_FDL;

    clrAlarm = rdEn && !rdBurst && !rdSel;
    clrEvent = rdEn && !rdBurst && rdSel;
    alarmNow = {live.yellow, live.blue, live.zero16, live.zero8, live.carrier};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusAlarm <= '0;
      statusClear <= '0;
    end else begin
      statusAlarm <= (clrAlarm ? 5'b0 : statusAlarm) | alarmNow;
      statusClear <= (clrEvent ? 2'b0 : statusClear) | {live.blueEnd, live.carrierEnd};
    end
  end

  assign irqN = ~(|(statusAlarm & maskAlarm) | |(statusClear & maskClear));

endmodule

// File: rtl/t1_alarm_detect.sv
module t1_alarm_detect
  import t1_alarm_pkg::*;
#(
  parameter int CL_RUN     = 192,
  parameter int CL_BLK     = 112,
  parameter int CL_ONES    = 14,
  parameter int AIS_WIN    = 4632,
  parameter int AIS_MAXZ   = 5,
  parameter int Y2_RUN     = 256,
  parameter int FDL_REPS   = 16,
  parameter int FRAME_SBIT = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxData,
  input  logic       fBitMark,
  input  logic [4:0] frameNum,
  input  logic [2:0] bitPos,
  input  logic       fdlMark,
  input  logic       esfMode,
  input  logic       sbitYelMode,
  input  logic       rdEn,
  input  logic       rdSel,
  input  logic       rdBurst,
  input  logic [4:0] maskAlarm,
  input  logic [1:0] maskClear,
  output logic       carrierLoss,
  output logic       zero8,
  output logic       zero16,
  output logic       blueAlarm,
  output logic       yellowAlarm,
  output logic [4:0] statusAlarm,
  output logic [1:0] statusClear,
  output logic       irqN
);

  strobe_t stb;
  live_t   live;

  t1_alarm_ctrl #(.FRAME_SBIT(FRAME_SBIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxData(rxData),
    .fBitMark(fBitMark), .frameNum(frameNum), .bitPos(bitPos),
    .fdlMark(fdlMark), .esfMode(esfMode), .sbitYelMode(sbitYelMode),
    .rdEn(rdEn), .rdSel(rdSel), .rdBurst(rdBurst),
    .maskAlarm(maskAlarm), .maskClear(maskClear), .live(live),
    .stb(stb), .statusAlarm(statusAlarm), .statusClear(statusClear),
    .irqN(irqN)
  );

  t1_alarm_path #(
    .CL_RUN(CL_RUN), .CL_BLK(CL_BLK), .CL_ONES(CL_ONES),
    .AIS_WIN(AIS_WIN), .AIS_MAXZ(AIS_MAXZ), .Y2_RUN(Y2_RUN),
    .FDL_REPS(FDL_REPS), .RUN_SHORT(8), .RUN_LONG(16)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .live(live)
  );

  assign carrierLoss = live.carrier;
  assign zero8       = live.zero8;
  assign zero16      = live.zero16;
  assign blueAlarm   = live.blue;
  assign yellowAlarm = live.yellow;

endmodule

// File: rtl/t1_alarm_checker.sv
module t1_alarm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       rdEn,
  input logic       rdSel,
  input logic       rdBurst,
  input logic       carrierLoss,
  input logic       zero8,
  input logic       zero16,
  input logic       blueAlarm,
  input logic       yellowAlarm,
  input logic [4:0] statusAlarm,
  input logic [1:0] statusClear,
  input logic       irqN
);

  assert_long_run_implies_short_R1: assert property (@(posedge clk) disable iff (!rstN)
    zero16 |-> zero8);

  assert_loss_after_long_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carrierLoss) |-> $past(zero16));

  assert_live_latches_R8: assert property (@(posedge clk) disable iff (!rstN)
    (carrierLoss || yellowAlarm) |=> (statusAlarm[0] || !$past(carrierLoss)) &&
                                     (statusAlarm[4] || !$past(yellowAlarm)));

  assert_status_drop_needs_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusAlarm[1]) |-> $past(rdEn && !rdBurst && !rdSel));

  assert_blue_end_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(blueAlarm) |=> statusClear[1]);

  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (|statusAlarm || |statusClear));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitEn) && rstN && $past(rstN) |-> $stable(zero8) && $stable(carrierLoss) && $stable(blueAlarm));

endmodule

bind t1_alarm_detect t1_alarm_checker u_checker (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .rdEn(rdEn), .rdSel(rdSel),
  .rdBurst(rdBurst), .carrierLoss(carrierLoss), .zero8(zero8),
  .zero16(zero16), .blueAlarm(blueAlarm), .yellowAlarm(yellowAlarm),
  .statusAlarm(statusAlarm), .statusClear(statusClear), .irqN(irqN)
);

// File: tb/t1_alarm_detect_bench.sv
module t1_alarm_detect_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0, rxData = 1'b0, fBitMark = 1'b0, fdlMark = 1'b0;
  logic [4:0] frameNum = 5'd1;
  logic [2:0] bitPos = 3'd0;
  logic       esfMode = 1'b0, sbitYelMode = 1'b0;
  logic       rdEn = 1'b0, rdSel = 1'b0, rdBurst = 1'b0;
  logic [4:0] maskAlarm = '0;
  logic [1:0] maskClear = '0;
  logic       carrierLoss, zero8, zero16, blueAlarm, yellowAlarm, irqN;
  logic [4:0] statusAlarm;
  logic [1:0] statusClear;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  t1_alarm_detect u_t1_alarm_detect (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxData(rxData),
    .fBitMark(fBitMark), .frameNum(frameNum), .bitPos(bitPos),
    .fdlMark(fdlMark), .esfMode(esfMode), .sbitYelMode(sbitYelMode),
    .rdEn(rdEn), .rdSel(rdSel), .rdBurst(rdBurst),
    .maskAlarm(maskAlarm), .maskClear(maskClear),
    .carrierLoss(carrierLoss), .zero8(zero8), .zero16(zero16),
    .blueAlarm(blueAlarm), .yellowAlarm(yellowAlarm),
    .statusAlarm(statusAlarm), .statusClear(statusClear), .irqN(irqN)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitEn = 1'b0; rdEn = 1'b0;
    end
  endtask

  task automatic sendBit(input logic b, input logic fb, input logic [4:0] fn,
                         input logic [2:0] bp, input logic fdl);
    @(negedge clk);
    bitEn = 1'b1; rxData = b; fBitMark = fb; frameNum = fn; bitPos = bp; fdlMark = fdl;
    rdEn = 1'b0;
  endtask

  task automatic sendRun(input logic b, input int n);
    for (int i = 0; i < n; i++) sendBit(b, 1'b0, 5'd1, 3'd0, 1'b0);
  endtask

  task automatic doRead(input logic sel, input logic burst);
    @(negedge clk);
    bitEn = 1'b0; rdEn = 1'b1; rdSel = sel; rdBurst = burst;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset(input logic esf, input logic sbit);
    @(negedge clk);
    rstN = 1'b0; bitEn = 1'b0; rdEn = 1'b0;
    esfMode = esf; sbitYelMode = sbit; maskAlarm = '0; maskClear = '0;
    settle(3);
    rstN = 1'b1;
    settle(1);
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b0);
    chk("R8 reset statusAlarm", statusAlarm, 0);
    chk("R9 reset statusClear", statusClear, 0);
    chk("R10 reset irqN", irqN, 1);
    chk("R2 reset carrierLoss", carrierLoss, 0);
  endtask

  task automatic testZeroRuns();
    doReset(1'b0, 1'b0);
    sendRun(1'b0, 7); settle(1);
    chk("R1 zero8 after 7", zero8, 0);
    sendRun(1'b0, 1); settle(1);
    chk("R1 zero8 after 8", zero8, 1);
    chk("R1 zero16 after 8", zero16, 0);
    settle(3);
    chk("R11 idle keeps zero8", zero8, 1);
    sendRun(1'b0, 7); settle(1);
    chk("R1 zero16 after 15", zero16, 0);
    sendRun(1'b0, 1); settle(2);
    chk("R1 zero16 after 16", zero16, 1);
    chk("R8 status 8/16 set", statusAlarm, 6);
    doRead(1'b0, 1'b0);
    chk("R8 read keeps present", statusAlarm, 6);
    sendRun(1'b1, 1); settle(1);
    chk("R1 zero8 cleared by one", zero8, 0);
    chk("R1 zero16 cleared by one", zero16, 0);
    doRead(1'b0, 1'b1);
    chk("R8 burst read keeps", statusAlarm, 6);
    maskAlarm = 5'b00100; settle(1);
    chk("R10 irq on masked zero16", irqN, 0);
    doRead(1'b0, 1'b0);
    chk("R8 normal read clears", statusAlarm, 0);
    chk("R10 irq released", irqN, 1);
  endtask

  task automatic testCarrier();
    doReset(1'b0, 1'b0);
    sendRun(1'b0, 191); settle(1);
    chk("R2 no loss at 191", carrierLoss, 0);
    sendRun(1'b0, 1); settle(1);
    chk("R2 loss at 192", carrierLoss, 1);
    sendRun(1'b1, 13); sendRun(1'b0, 99); settle(1);
    chk("R3 13 ones keeps loss", carrierLoss, 1);
    sendRun(1'b1, 14); sendRun(1'b0, 97); settle(1);
    chk("R3 before block end", carrierLoss, 1);
    sendRun(1'b0, 1); settle(2);
    chk("R3 14 ones clears loss", carrierLoss, 0);
    chk("R9 carrier end event", statusClear, 1);
    chk("R8 carrier status kept", statusAlarm[0], 1);
    doRead(1'b1, 1'b0);
    chk("R9 read clears events", statusClear, 0);
  endtask

  task automatic testBlue();
    doReset(1'b0, 1'b0);
    sendRun(1'b1, 4631); settle(1);
    chk("R4 no blue before window end", blueAlarm, 0);
    sendRun(1'b1, 1); settle(1);
    chk("R4 blue at window end", blueAlarm, 1);
    sendRun(1'b0, 5); sendRun(1'b1, 4627); settle(1);
    chk("R4 five zeros keep blue", blueAlarm, 1);
    sendRun(1'b0, 6); sendRun(1'b1, 4625); settle(1);
    chk("R4 blue held mid window", blueAlarm, 1);
    sendRun(1'b1, 1); settle(2);
    chk("R4 six zeros clear blue", blueAlarm, 0);
    chk("R9 blue end event", statusClear, 2);
    chk("R10 events unmasked no irq", irqN, 1);
    maskClear = 2'b10; settle(1);
    chk("R10 irq on blue end", irqN, 0);
    doRead(1'b1, 1'b0);
    chk("R9 blue event cleared", statusClear, 0);
    chk("R10 irq released after read", irqN, 1);
  endtask

  task automatic testYellowBit2();
    doReset(1'b0, 1'b0);
    for (int i = 0; i < 255; i++) sendBit(1'b0, 1'b0, 5'd1, 3'd1, 1'b0);
    settle(1);
    chk("R5 no yellow at 255", yellowAlarm, 0);
    sendBit(1'b0, 1'b0, 5'd1, 3'd1, 1'b0); settle(1);
    chk("R5 yellow at 256", yellowAlarm, 1);
    sendBit(1'b1, 1'b0, 5'd1, 3'd2, 1'b0); settle(1);
    chk("R5 other position ignored", yellowAlarm, 1);
    sendBit(1'b1, 1'b0, 5'd1, 3'd1, 1'b0); settle(2);
    chk("R5 bit2 one clears", yellowAlarm, 0);
    chk("R8 yellow latched", statusAlarm[4], 1);
  endtask

  task automatic testYellowSbit();
    doReset(1'b0, 1'b1);
    sendBit(1'b1, 1'b1, 5'd12, 3'd0, 1'b0); settle(1);
    chk("R6 frame12 one sets", yellowAlarm, 1);
    sendBit(1'b0, 1'b1, 5'd11, 3'd0, 1'b0); settle(1);
    chk("R6 other frame ignored", yellowAlarm, 1);
    sendBit(1'b0, 1'b1, 5'd12, 3'd0, 1'b0); settle(1);
    chk("R6 frame12 zero clears", yellowAlarm, 0);
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i], 1'b1, 5'd2, 3'd0, 1'b1);
  endtask

  task automatic testYellowFdl();
    doReset(1'b1, 1'b0);
    for (int r = 0; r < 15; r++) sendWord(16'h00FF);
    settle(1);
    chk("R7 no yellow after 15", yellowAlarm, 0);
    sendWord(16'h00FF); settle(1);
    chk("R7 yellow after 16", yellowAlarm, 1);
    sendWord(16'h00FE); settle(1);
    chk("R7 other word clears", yellowAlarm, 0);
  endtask

  initial begin
    testReset();
    testZeroRuns();
    testCarrier();
    testBlue();
    testYellowBit2();
    testYellowSbit();
    testYellowFdl();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule